// File: doc/BRIEF.md
# Split Read/Write Bank Aperture

This block steers accesses through a display adapter's legacy 64 KB memory window into a much larger linear video memory. It keeps two bank registers. The write bank places every store that passes through the window, and the read bank places every load. Software can therefore copy from one region of video memory to another through the same small window, for example when scrolling text, without reprogramming a bank for each access.

A single 16-bit bank-select write programs the banks. The two top bits of the value pick the target: the write bank, the read bank, or both. When both of those bits are zero the write updates both banks, which keeps older software that knows nothing of the split working as before. The bank number comes from the low nine bits of the value. It is accepted only when it falls below the number of banks that the memory holds at the current granularity. That count is 1/4 as large in the planar 4 bpp mode.

For each window access the block gives the linear offset, the memory enable, and a flag that tells the data path to return all ones for a read outside the window. It also gives the plane offset, which follows the write bank.

Top module: `bank_aperture`

## Requirements
- R1: After reset both banks are 0, the granularity is 64 KB, `cfg_rdata` is 0 and `plane_offset` is 0.
- R2: On `cfg_wr`, bits [15:14] of `cfg_wdata` choose the target. 2'b01 updates the write bank only, 2'b10 updates the read bank only, and 2'b11 or 2'b00 updates both. The new values are visible from the next clock edge.
- R3: The bank number is `cfg_wdata[8:0]`. Bits [13:9] have no effect on the number or on whether it is accepted.
- R4: A bank number is accepted only when it is less than VMEM_KB/64 (granularity 64 KB) or VMEM_KB/32 (granularity 32 KB). In planar mode (`planar_4bpp`=1) the limit is divided by 4. A rejected write leaves both banks unchanged.
- R5: For a read access (`acc_write`=0), `mem_offset` = (read_bank × granularity_bytes + `acc_addr[15:0]`) modulo the memory size in bytes.
- R6: For a write access (`acc_write`=1), `mem_offset` uses the same formula with the write bank.
- R7: A `cfg_rd` pulse loads `cfg_rdata` at the next edge with the write bank, zero-extended. The read bank is never returned.
- R8: The granularity register follows `gran_sel_32k` (1 = 32 KB). In any cycle where the input differs from the register, the register takes the new value and both banks clear to 0 at that edge, and a bank write in the same cycle is discarded.
- R9: `plane_offset` = write_bank << 16 at 64 KB granularity and write_bank << 15 at 32 KB granularity.
- R10: `mem_en` is high only for `acc_valid` with `acc_addr` < 0xB0000. `oob_read_ones` is high for `acc_valid`, `acc_write`=0 and `acc_addr` >= 0xB0000. A write at or above 0xB0000 raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Bank-select write strobe, one cycle |
| cfg_wdata | input | 16 | Bank-select write value |
| cfg_rd | input | 1 | Bank-select read strobe |
| cfg_rdata | output | 16 | Read-back value (write bank) |
| gran_sel_32k | input | 1 | Granularity select: 1 = 32 KB, 0 = 64 KB |
| planar_4bpp | input | 1 | Planar 4 bpp mode, reduces the bank count |
| acc_valid | input | 1 | Window access present |
| acc_write | input | 1 | Access direction: 1 = write |
| acc_addr | input | 20 | Physical address of the access |
| mem_en | output | 1 | Access maps into video memory |
| mem_offset | output | 24 | Linear video memory offset |
| oob_read_ones | output | 1 | Out-of-window read, return all ones |
| plane_offset | output | 24 | Plane offset derived from the write bank |

## Verification
The bench programs the read and write banks with different values, then issues loads and stores on alternating cycles. A design that swapped the banks, or fed both directions from one register, gives a wrong offset on one of the two. It drives the target field as 00, 01, 10 and 11 and checks that an encoding of 00 updates both banks rather than neither. It sets junk in bits [13:9] to catch a bank number decoded from too many bits. It writes numbers exactly at the bank limit and one below it, at both granularities and in planar mode, which exposes an off-by-one or a planar limit that was never divided. It also changes the granularity in the same cycle as a bank write, to catch a design that keeps the stale bank or applies the discarded write.

// File: rtl/bank_aperture.sv
module bank_aperture #(
  parameter int VMEM_KB = 16384,
  parameter int ADDR_W  = 20,
  parameter int BANK_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_wdata,
  input  logic              cfg_rd,
  output logic [15:0]       cfg_rdata,
  input  logic              gran_sel_32k,
  input  logic              planar_4bpp,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              mem_en,
  output logic [23:0]       mem_offset,
  output logic              oob_read_ones,
  output logic [23:0]       plane_offset
);
  localparam int OFF_W      = $clog2(VMEM_KB) + 10;
  localparam int BANKS_64K  = VMEM_KB / 64;
  localparam int BANKS_32K  = VMEM_KB / 32;
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(20'hB0000);

  logic              gran_q;
  logic [BANK_W-1:0] wbank, rbank;
  logic [15:0]       rdata_q;

  logic              gran_chg;
  logic [1:0]        tgt;
  logic [BANK_W-1:0] num;
  logic [31:0]       limit;
  logic              num_ok;

  assign gran_chg = gran_sel_32k != gran_q;
  assign tgt      = (cfg_wdata[15:14] == 2'b00) ? 2'b11 : cfg_wdata[15:14];
  assign num      = cfg_wdata[BANK_W-1:0];
  assign limit    = (gran_q ? 32'(BANKS_32K) : 32'(BANKS_64K)) >> (planar_4bpp ? 2 : 0);
  assign num_ok   = 32'(num) < limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gran_q  <= 1'b0;
      wbank   <= '0;
      rbank   <= '0;
      rdata_q <= '0;
    end else begin
      if (gran_chg) begin
        gran_q <= gran_sel_32k;
        wbank  <= '0;
        rbank  <= '0;
      end else if (cfg_wr && num_ok) begin
        if (tgt[0]) wbank <= num;
        if (tgt[1]) rbank <= num;
      end
      if (cfg_rd) rdata_q <= 16'(wbank);
    end
  end

  assign cfg_rdata = rdata_q;

  logic [BANK_W-1:0] sel_bank;
  logic [31:0]       base, sum;

  assign sel_bank = acc_write ? wbank : rbank;
  assign base     = gran_q ? (32'(sel_bank) << 15) : (32'(sel_bank) << 16);
  assign sum      = base + 32'(acc_addr[15:0]);

  assign mem_offset    = 24'(sum[OFF_W-1:0]);
  assign mem_en        = acc_valid && (acc_addr < WIN_END);
  assign oob_read_ones = acc_valid && !acc_write && (acc_addr >= WIN_END);
  assign plane_offset  = 24'(gran_q ? (32'(wbank) << 15) : (32'(wbank) << 16));
endmodule

// File: rtl/bank_aperture_chk.sv
module bank_aperture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [15:0] cfg_wdata,
  input logic        cfg_rd,
  input logic [15:0] cfg_rdata,
  input logic        gran_sel_32k,
  input logic        gran_q,
  input logic        planar_4bpp,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [19:0] acc_addr,
  input logic        mem_en,
  input logic        oob_read_ones,
  input logic [8:0]  wbank,
  input logic [8:0]  rbank
);
  // R2
  write_only_keeps_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[15:14] == 2'b01 && gran_sel_32k == gran_q |=> $stable(rbank));
  // R2
  read_only_keeps_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[15:14] == 2'b10 && gran_sel_32k == gran_q |=> $stable(wbank));
  // R4
  planar_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && planar_4bpp && !gran_q && !gran_sel_32k && cfg_wdata[8:0] >= 9'd64
    |=> $stable(wbank) && $stable(rbank));
  // R7
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rdata == 16'($past(wbank)));
  // R8
  gran_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gran_sel_32k != gran_q |=> wbank == 9'd0 && rbank == 9'd0);
  // R10
  oob_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_addr >= 20'hB0000 |-> !mem_en);
  // R10
  oob_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write |-> !oob_read_ones);
  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr && gran_sel_32k == gran_q |=> $stable(wbank) && $stable(rbank));
endmodule

bind bank_aperture bank_aperture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .gran_sel_32k(gran_sel_32k),
  .gran_q(gran_q), .planar_4bpp(planar_4bpp), .acc_valid(acc_valid),
  .acc_write(acc_write), .acc_addr(acc_addr), .mem_en(mem_en),
  .oob_read_ones(oob_read_ones), .wbank(wbank), .rbank(rbank)
);

// File: tb/bank_aperture_bench.sv
module bank_aperture_bench;
  localparam int VMEM_KB = 16384;
  localparam int MEM_BYTES = VMEM_KB * 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        cfg_rd = 1'b0;
  logic [15:0] cfg_rdata;
  logic        gran_sel_32k = 1'b0;
  logic        planar_4bpp = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [19:0] acc_addr = '0;
  logic        mem_en;
  logic [23:0] mem_offset;
  logic        oob_read_ones;
  logic [23:0] plane_offset;

  always #2 clk = ~clk;

  bank_aperture u_bank_aperture (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .gran_sel_32k(gran_sel_32k),
    .planar_4bpp(planar_4bpp), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .mem_en(mem_en), .mem_offset(mem_offset),
    .oob_read_ones(oob_read_ones), .plane_offset(plane_offset)
  );

  int m_wb, m_rb, m_g32, m_rd;
  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    int owb, lim, num, tg;
    owb = m_wb;
    if (!rst_n) begin
      m_wb = 0; m_rb = 0; m_g32 = 0; m_rd = 0;
    end else begin
      if (int'(gran_sel_32k) != m_g32) begin
        m_g32 = gran_sel_32k; m_wb = 0; m_rb = 0;
      end else if (cfg_wr) begin
        lim = m_g32 ? VMEM_KB / 32 : VMEM_KB / 64;
        if (planar_4bpp) lim = lim / 4;
        num = cfg_wdata & 16'h1FF;
        tg = cfg_wdata >> 14;
        if (tg == 0) tg = 3;
        if (num < lim) begin
          if (tg & 1) m_wb = num;
          if (tg & 2) m_rb = num;
        end
      end
      if (cfg_rd) m_rd = owb;
    end
  end

  task automatic cmp(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    longint bank, off, gb;
    if (rst_n && !done) begin
      bank = acc_write ? m_wb : m_rb;
      gb = m_g32 ? 32768 : 65536;
      off = (bank * gb + (acc_addr & 20'hFFFF)) % MEM_BYTES;
      cmp(acc_write ? "R6 write offset" : "R5 read offset", mem_offset, off);
      cmp("R7 readback", cfg_rdata, m_rd);
      cmp("R9 plane offset", plane_offset, m_wb * gb);
      cmp("R10 mem_en", mem_en, acc_valid && acc_addr < 20'hB0000);
      cmp("R10 oob read", oob_read_ones, acc_valid && !acc_write && acc_addr >= 20'hB0000);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // one bank-select write, then a load and a store through the window
  task automatic wr_bank(logic [15:0] v, logic [19:0] a);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_wdata = v; cfg_rd = 0; acc_valid = 0;
    @(posedge clk); #1;
    cfg_wr = 0; cfg_rd = 1; acc_valid = 1; acc_write = 0; acc_addr = a;
    @(posedge clk); #1;
    cfg_rd = 0; acc_write = 1;
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state at the ports
    cmp("R1 rdata", cfg_rdata, 0);
    cmp("R1 plane", plane_offset, 0);
    rst_n = 1;
    acc_valid = 1; acc_write = 0; acc_addr = 20'hA1234;
    @(posedge clk); #1;
    cmp("R1 read offset", mem_offset, 24'h001234);
    // R2 compatibility encoding 00 updates both
    wr_bank(16'h0005, 20'hA0010);
    // R2 write only, read only, both
    wr_bank(16'h400A, 20'hAFFFF);
    wr_bank(16'h8014, 20'hA8000);
    wr_bank(16'hC01E, 20'hA0001);
    wr_bank(16'h4033, 20'hA4321);
    // R3 junk in bits 13:9
    wr_bank(16'h3E07, 20'hA0100);
    wr_bank(16'h7EFF, 20'hA0200);
    // R4 64 KB limit 256: 255 ok, 256 rejected, 300 rejected
    wr_bank(16'h00FF, 20'hAFFFF);
    wr_bank(16'h0100, 20'hA0000);
    wr_bank(16'h812C, 20'hA0000);
    // R8 granularity change clears, concurrent write discarded
    @(posedge clk); #1;
    gran_sel_32k = 1; cfg_wr = 1; cfg_wdata = 16'h0009;
    @(posedge clk); #1;
    cfg_wr = 0;
    wr_bank(16'h0000, 20'hA1111);
    // R4 32 KB limit 512: 300 and 511 ok
    wr_bank(16'h412C, 20'hAFFFF);
    wr_bank(16'h81FF, 20'hAFFFF);
    // R4 planar at 32 KB: limit 128
    planar_4bpp = 1;
    wr_bank(16'h007F, 20'hA2000);
    wr_bank(16'h0080, 20'hA2000);
    // R4 planar at 64 KB: limit 64
    gran_sel_32k = 0;
    @(posedge clk); #1;
    wr_bank(16'h003F, 20'hA3000);
    wr_bank(16'h0040, 20'hA3000);
    wr_bank(16'hC020, 20'hA3000);
    planar_4bpp = 0;
    // R10 window edges in both directions
    wr_bank(16'h4044, 20'hAFFFF);
    wr_bank(16'h8055, 20'hB0000);
    wr_bank(16'h0011, 20'hC1234);
    wr_bank(16'h0012, 20'h9FFFF);
    repeat (2) @(posedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule